// File: doc/BRIEF.md
# Memory Data Line Test Engine

The engine checks the data wires between a chip and a 64-bit external memory for shorts and opens. A pulse on the start input runs one pass against a single base word. For each entry of a fixed list of adjacency patterns, the engine does three things in order:

- It writes the pattern to the base word.
- It writes a fixed, unrelated word to the next address. This recharges the bus, so a floating line cannot keep the pattern it just carried.
- It reads the base word back once and compares that single sample with the pattern.

A mismatch does not end the pass. Every pattern is always tried. A sticky flag, a capture of the first failure and a saturating count of failures report the result. The memory side is a plain synchronous master. Each request is taken in the cycle it is asserted, and read data arrives later, marked by a valid strobe. This lets the engine serve memories with any read latency.

Top module: `dbt_line_tester`

## Requirements
- R1: The pass uses twelve 64-bit patterns in a fixed order. For pattern k with k from 0 to 5, bit b equals bit k of the number b. This gives, in order, AAAA.., CCCC.., F0F0.., FF00FF00.., FFFF0000FFFF0000 and FFFFFFFF00000000. For k from 6 to 11, the pattern is the bitwise complement of pattern 11-k.
- R2: For each pattern the engine issues exactly three requests, one per cycle and in this order: a write of the pattern to the base address; a write of 0x0123456789ABCDEF to the base address plus one (wrapping at the address width); a read of the base address.
- R3: The engine issues exactly one read per pattern. It takes read data in the first cycle after the read request in which the valid strobe is high, for a read latency L of 1 or more cycles. It issues no request while it waits.
- R4: A mismatch never ends the pass. All twelve patterns always run. Counting the cycle after the accepting clock edge as cycle 1, done is high in cycle 12*(3+L)+1.
- R5: The error flag is sticky through the end of the pass. It, the counter and the capture registers return to zero on the edge that accepts the next start.
- R6: On the first mismatch of a pass, the capture registers take the failing address, the expected word and the word read. Later mismatches leave them unchanged.
- R7: The error counter holds the number of mismatches in the pass and saturates at 2^CNT_W-1.
- R8: Done is a one-cycle pulse. Busy is high from the cycle after the accepted start through the done cycle, and low in the following cycle.
- R9: A start pulse while busy is high, including in the done cycle, is ignored. No extra request appears and the pass length is unchanged.
- R10: After reset, busy, done, error, count, the capture registers and the memory request are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| base_addr_i | input | ADDR_W | Word address under test, sampled at start |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle end-of-pass pulse |
| err_o | output | 1 | Sticky mismatch flag |
| err_cnt_o | output | CNT_W | Saturating mismatch count |
| err_addr_o | output | ADDR_W | Address of first mismatch |
| err_exp_o | output | 64 | Expected word of first mismatch |
| err_obs_o | output | 64 | Observed word of first mismatch |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Request word address |
| mem_wdata_o | output | 64 | Write data |
| mem_rdata_i | input | 64 | Read data |
| mem_rvalid_i | input | 1 | Read data valid |

## Verification
Two events can share a cycle: the end of a pass and a new start pulse. The bench drives start high in the exact cycle where done is seen. It then checks that busy and the request line are low in the next cycle and that no further request appears. The bench also raises start in the middle of a pass and confirms that the pass length and request count match an undisturbed run. A floating-bus fault makes every pattern fail. In that run the counter reaches saturation while later mismatches are still being strobed, and the bench checks that the first capture survives them.

// File: rtl/dbt_pkg.sv
// Package: shared constants, sequencer state type and the adjacency
// pattern function for the data line test engine.
// Assumes a 64-bit data path; the pattern count follows from it.
package dbt_pkg;

    localparam int DATA_W  = 64;
    localparam int LOG_W   = $clog2(DATA_W);
    localparam int NUM_PAT = 2 * LOG_W;
    localparam int IDX_W   = $clog2(NUM_PAT);
    localparam logic [DATA_W-1:0] DISTURB_WORD = 64'h0123_4567_89AB_CDEF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WPAT,
        ST_WDIS,
        ST_RREQ,
        ST_WAIT,
        ST_DONE
    } seq_state_e;

    // Pattern k: bit b = bit k of b for the first half, then complements
    // of the first half taken in reverse order.
    function automatic logic [DATA_W-1:0] adj_pattern(input int k);
        logic [DATA_W-1:0] v;
        for (int b = 0; b < DATA_W; b++) begin
            if (k < LOG_W)
                v[b] = ((b >> k) & 1) != 0;
            else
                v[b] = ((b >> (NUM_PAT - 1 - k)) & 1) == 0;
        end
        return v;
    endfunction

endpackage

// File: rtl/dbt_pattern_gen.sv
// Pattern source: builds the adjacency pattern list as constants and
// selects one by index. Indices past the list return zero.
module dbt_pattern_gen
    import dbt_pkg::*;
(
    input  logic [IDX_W-1:0]  idx_i,
    output logic [DATA_W-1:0] pat_o
);

    localparam int TBL_N = 2 ** IDX_W;

    logic [DATA_W-1:0] tbl [TBL_N];

    // Fill the table: real patterns first, zero padding after.
    for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
        if (g < NUM_PAT) begin : g_pat
            assign tbl[g] = adj_pattern(g);
        end else begin : g_pad
            assign tbl[g] = '0;
        end
    end

    // Select the current pattern.
    assign pat_o = tbl[idx_i];

endmodule

// File: rtl/dbt_sequencer.sv
// Sequencer: walks the pattern list, issuing write-pattern,
// write-disturb and one read per pattern, then waits for read valid.
// Assumes the memory accepts a request in the cycle it is asserted
// and returns read data at least one cycle after the read request.
module dbt_sequencer
    import dbt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [DATA_W-1:0] pat_i,
    output logic [IDX_W-1:0]  pat_idx_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              clr_o,
    output logic              cmp_vld_o,
    output logic [ADDR_W-1:0] cmp_addr_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_rvalid_i
);

    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_PAT - 1);
    localparam logic [ADDR_W-1:0] ONE_ADDR = ADDR_W'(1);

    seq_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] base_q;
    logic              start_acc;
    logic              last_pat;

    assign start_acc = (state_q == ST_IDLE) && start_i;
    assign last_pat  = (idx_q == LAST_IDX);

    // Next-state selection for one pass.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_WPAT;
            ST_WPAT: state_d = ST_WDIS;
            ST_WDIS: state_d = ST_RREQ;
            ST_RREQ: state_d = ST_WAIT;
            ST_WAIT: if (mem_rvalid_i) state_d = last_pat ? ST_DONE : ST_WPAT;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Pattern index: cleared at start, advanced after each read-back.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (start_acc)
            idx_q <= '0;
        else if (state_q == ST_WAIT && mem_rvalid_i && !last_pat)
            idx_q <= idx_q + IDX_W'(1);
    end

    // Base address latch, taken when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)         base_q <= '0;
        else if (start_acc) base_q <= base_addr_i;
    end

    // Memory request decode from the state.
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = base_q;
        mem_wdata_o = pat_i;
        unique case (state_q)
            ST_WPAT: begin
                mem_req_o = 1'b1;
                mem_we_o  = 1'b1;
            end
            ST_WDIS: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = base_q + ONE_ADDR;
                mem_wdata_o = DISTURB_WORD;
            end
            ST_RREQ: mem_req_o = 1'b1;
            default: ;
        endcase
    end

    // Status and compare strobes toward the capture block.
    assign pat_idx_o  = idx_q;
    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = (state_q == ST_DONE);
    assign clr_o      = start_acc;
    assign cmp_vld_o  = (state_q == ST_WAIT) && mem_rvalid_i;
    assign cmp_addr_o = base_q;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
    // R9
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
    // R2
    disturb_before_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o) |-> $past(mem_req_o && mem_we_o && mem_wdata_o == DISTURB_WORD));
    // R3
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o) |=> !mem_req_o);

endmodule

// File: rtl/dbt_err_capture.sv
// Error capture: compares each read-back with its pattern, keeps a
// sticky flag, the first failure's address and words, and a
// saturating mismatch counter. Everything clears on a new start.
module dbt_err_capture
    import dbt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              cmp_vld_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] exp_i,
    input  logic [DATA_W-1:0] obs_i,
    output logic              err_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] exp_o,
    output logic [DATA_W-1:0] obs_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic mismatch;

    assign mismatch = cmp_vld_i && (obs_i != exp_i);

    // Sticky flag and saturating counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            err_o <= 1'b0;
            cnt_o <= '0;
        end else if (mismatch) begin
            err_o <= 1'b1;
            if (cnt_o != CNT_MAX) cnt_o <= cnt_o + CNT_W'(1);
        end
    end

    // First-failure capture of address, expected and observed words.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            addr_o <= '0;
            exp_o  <= '0;
            obs_o  <= '0;
        end else if (mismatch && !err_o) begin
            addr_o <= addr_i;
            exp_o  <= exp_i;
            obs_o  <= obs_i;
        end
    end

    // R5
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_o) && !err_o) |-> $past(clr_i));
    // R6
    first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && $past(err_o)) |-> ($stable(exp_o) && $stable(obs_o) && $stable(addr_o)));
    // R7
    count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_o) == CNT_MAX && !$past(clr_i)) |-> (cnt_o == CNT_MAX));
    // R7
    count_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o != '0) |-> err_o);

endmodule

// File: rtl/dbt_line_tester.sv
// Top of the data line test engine: ties the pattern source, the
// sequencer and the error capture together. Assumes a single base word
// under test and a request-taken-when-asserted memory port.
module dbt_line_tester
    import dbt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [CNT_W-1:0]  err_cnt_o,
    output logic [ADDR_W-1:0] err_addr_o,
    output logic [63:0]       err_exp_o,
    output logic [63:0]       err_obs_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [63:0]       mem_wdata_o,
    input  logic [63:0]       mem_rdata_i,
    input  logic              mem_rvalid_i
);

    logic [IDX_W-1:0]  pat_idx;
    logic [DATA_W-1:0] pat;
    logic              clr;
    logic              cmp_vld;
    logic [ADDR_W-1:0] cmp_addr;

    dbt_pattern_gen u_pat (
        .idx_i (pat_idx),
        .pat_o (pat)
    );

    dbt_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .base_addr_i  (base_addr_i),
        .pat_i        (pat),
        .pat_idx_o    (pat_idx),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .clr_o        (clr),
        .cmp_vld_o    (cmp_vld),
        .cmp_addr_o   (cmp_addr),
        .mem_req_o    (mem_req_o),
        .mem_we_o     (mem_we_o),
        .mem_addr_o   (mem_addr_o),
        .mem_wdata_o  (mem_wdata_o),
        .mem_rvalid_i (mem_rvalid_i)
    );

    dbt_err_capture #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .cmp_vld_i (cmp_vld),
        .addr_i    (cmp_addr),
        .exp_i     (pat),
        .obs_i     (mem_rdata_i),
        .err_o     (err_o),
        .cnt_o     (err_cnt_o),
        .addr_o    (err_addr_o),
        .exp_o     (err_exp_o),
        .obs_o     (err_obs_o)
    );

endmodule

// File: tb/dbt_line_tester_bench.sv
module dbt_line_tester_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int CW = 3;
    localparam logic [63:0] DIST = 64'h0123456789ABCDEF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic busy_o, done_o, err_o;
    logic [CW-1:0] err_cnt_o;
    logic [AW-1:0] err_addr_o, mem_addr_o;
    logic [63:0] err_exp_o, err_obs_o, mem_wdata_o, mem_rdata;
    logic mem_req_o, mem_we_o, mem_rvalid;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbt_line_tester #(.ADDR_W(AW), .CNT_W(CW)) u_dbt_line_tester (
        .clk(clk), .rst_n(rst_n), .start_i(start), .base_addr_i(base_addr),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_cnt_o(err_cnt_o),
        .err_addr_o(err_addr_o), .err_exp_o(err_exp_o), .err_obs_o(err_obs_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata), .mem_rvalid_i(mem_rvalid)
    );

    // Expected pattern list (R1), written out.
    logic [63:0] pats [12] = '{
        64'hAAAAAAAAAAAAAAAA, 64'hCCCCCCCCCCCCCCCC, 64'hF0F0F0F0F0F0F0F0,
        64'hFF00FF00FF00FF00, 64'hFFFF0000FFFF0000, 64'hFFFFFFFF00000000,
        64'h00000000FFFFFFFF, 64'h0000FFFF0000FFFF, 64'h00FF00FF00FF00FF,
        64'h0F0F0F0F0F0F0F0F, 64'h3333333333333333, 64'h5555555555555555};

    // Memory model with configurable latency and faults.
    int          cfg_lat = 1;
    logic [63:0] cfg_stuck = '0;
    bit          cfg_float = 0;
    logic [63:0] mem [16];
    logic [63:0] last_wd = '0;
    logic [3:0]  rd_idx = '0;
    int          rd_cnt = 0;

    always @(posedge clk) begin
        if (rd_cnt > 0) rd_cnt <= rd_cnt - 1;
        if (mem_req_o) begin
            if (mem_we_o) begin
                mem[mem_addr_o[3:0]] <= mem_wdata_o;
                last_wd <= mem_wdata_o;
            end else begin
                rd_idx <= mem_addr_o[3:0];
                rd_cnt <= cfg_lat;
            end
        end
    end
    assign mem_rvalid = (rd_cnt == 1);
    assign mem_rdata  = cfg_float ? last_wd : (mem[rd_idx] & ~cfg_stuck);

    // Request monitor: compares each request with R2 ordering.
    int mon_idx = 0;
    int mon_bad = 0;
    logic [AW-1:0] mon_base = '0;
    always @(negedge clk) begin
        if (rst_n && mem_req_o) begin
            int k, p;
            k = mon_idx % 3;
            p = mon_idx / 3;
            if (p >= 12) mon_bad <= mon_bad + 1;
            else if (k == 0 && !(mem_we_o && mem_addr_o == mon_base && mem_wdata_o == pats[p]))
                mon_bad <= mon_bad + 1;
            else if (k == 1 && !(mem_we_o && mem_addr_o == mon_base + AW'(1) && mem_wdata_o == DIST))
                mon_bad <= mon_bad + 1;
            else if (k == 2 && !(!mem_we_o && mem_addr_o == mon_base))
                mon_bad <= mon_bad + 1;
            mon_idx <= mon_idx + 1;
        end
    end

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // One pass with the given memory behaviour; checks all results.
    task automatic run_case(int lat, logic [63:0] stuck, bit flt, logic [AW-1:0] base,
                            bit mid_start, bit done_start);
        int n;
        int exp_cnt;
        logic [63:0] e_exp, e_obs, obs;
        cfg_lat = lat; cfg_stuck = stuck; cfg_float = flt;
        @(negedge clk);
        mon_idx = 0; mon_bad = 0; mon_base = base;
        base_addr = base; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R8", "busy after start", 64'(busy_o), 64'd1);
        check("R5", "error cleared at start", {err_o, 60'd0, err_cnt_o}, 64'd0);
        n = 1;
        while (!done_o && n < 2000) begin
            start = (mid_start && n == 10);
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check("R4", "cycles to done", 64'(n), 64'(12 * (3 + lat) + 1));
        check("R8", "busy in done cycle", 64'(busy_o), 64'd1);
        if (done_start) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8", "done single pulse", 64'(done_o), 64'd0);
        check("R9", "idle after done", {busy_o, mem_req_o}, 64'd0);
        repeat (3) @(negedge clk);
        check("R9", "busy stays low", 64'(busy_o), 64'd0);
        check("R2", "request count", 64'(mon_idx), 64'd36);
        check("R3", "request order and single read", 64'(mon_bad), 64'd0);
        exp_cnt = 0; e_exp = '0; e_obs = '0;
        for (int p = 0; p < 12; p++) begin
            obs = flt ? DIST : (pats[p] & ~stuck);
            if (obs != pats[p]) begin
                if (exp_cnt == 0) begin e_exp = pats[p]; e_obs = obs; end
                exp_cnt++;
            end
        end
        if (exp_cnt > 7) exp_cnt = 7;
        check("R5", "error flag", 64'(err_o), 64'(exp_cnt != 0));
        check("R7", "error count", 64'(err_cnt_o), 64'(exp_cnt));
        check("R6", "captured expected", err_exp_o, e_exp);
        check("R6", "captured observed", err_obs_o, e_obs);
        check("R6", "captured address", 64'(err_addr_o), (exp_cnt != 0) ? 64'(base) : 64'd0);
    endtask

    task automatic test_reset();
        check("R10", "reset outputs",
              {busy_o, done_o, err_o, mem_req_o, 57'd0, err_cnt_o}, 64'd0);
        check("R10", "reset capture", err_exp_o | err_obs_o | 64'(err_addr_o), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL R4 watchdog expired: actual hung expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        run_case(1, '0, 0, 16'h0004, 0, 0);          // R1 R2 clean, latency 1
        run_case(3, '0, 0, 16'hFFFF, 0, 0);          // R2 wrap, R3 latency 3
        run_case(2, 64'h20, 0, 16'h0008, 0, 0);      // R6 R7 stuck bit
        run_case(1, '0, 1, 16'h0002, 0, 0);          // R4 R7 floating bus saturation
        run_case(1, '0, 0, 16'h0002, 1, 1);          // R5 clear, R9 ignored starts
        run_case(4, 64'h8000_0000_0000_0001, 0, 16'h0001, 0, 1); // R6 other fault
        finish_run();
    end

endmodule